// File: doc/BRIEF.md
# SPI Flash Identification and Status Responder

This block is an SPI mode-0 target that answers the identification and status commands of a serial NOR flash, with no memory array behind it. A host that probes a flash device at start-up can read back fixed identity bytes, poll the status register and update its protection bits. Everything runs in a single system clock domain. SCLK, chip select and MOSI are sampled on that clock, so SCLK must stay below a quarter of the system clock rate.

Each received byte goes to a command sequencer, a state machine with these states:
- S_OPCODE waits for a command byte.
- S_ID_READ serves the three-byte identity read.
- S_MFR_DEV serves the dummy/selector/two-ID sequence.
- S_DEV_READ serves the three-dummy device ID read.
- S_STAT_READ repeats the status byte.
- S_STAT_WRITE collects a status write.
- S_DRAIN ignores everything until chip select rises.

The transitions are:
- S_OPCODE goes to a command state when an opcode completes.
- A command state goes to S_DRAIN once its sequence is used up. Unknown opcodes, write-enable and write-disable also go straight to S_DRAIN.
- Any state returns to S_OPCODE when chip select goes high.

The manufacturer, memory-type and device ID values are parameters.

Top module: `spi_flash_responder`

## Requirements
- R1: After opcode 0x9F the next three bytes on MISO are MFR_ID, MEM_TYPE and DEV_ID in that order. Later bytes in the same transfer read 0x00.
- R2: After opcode 0x90, two dummy bytes and a selector byte, the next two bytes are MFR_ID then DEV_ID when selector bit 0 is 0, and DEV_ID then MFR_ID when it is 1.
- R3: After opcode 0xAB and three dummy bytes, the next byte is DEV_ID.
- R4: After opcode 0x05 the status byte is sent repeatedly for as long as SCLK runs with chip select low.
- R5: The status byte has the following layout:
  - bit 0: write-in-progress, always 0.
  - bit 1: write-enable latch.
  - bits 5:2: block-protect.
  - bit 6: continuous-program flag.
  - bit 7: status-write-disable.

  After reset the status byte is 0x00.
- R6: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it, effective when the opcode byte completes.
- R7: Opcode 0x01 followed by one or two bytes writes bits 7:2 of the first byte into status bits 7:2, and clears the latch. The write is applied when chip select rises on a byte boundary. Bits 1:0 of the data and any second byte are ignored.
- R8: A status write is discarded, with the latch left unchanged, when the latch is clear, or when status bit 7 is set and wp_n is low.
- R9: A status write is not applied when chip select rises in the middle of a byte, or before a complete data byte. A partial byte is discarded and the next transfer starts with an opcode.
- R10: MISO is high-impedance while cs_n is high. While cs_n is low it changes only after a falling SCLK edge. MOSI is sampled on rising SCLK edges, MSB first.
- R11: An unknown opcode leaves the status unchanged and MISO reads 0x00 for the rest of the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | SPI chip select, active low |
| sclk | input | 1 | SPI serial clock, mode 0 |
| mosi | input | 1 | Serial data from host |
| wp_n | input | 1 | Write-protect input, active low |
| miso | output | 1 | Serial data to host, tri-stated when deselected |

## Verification
On every cycle the assertions check four things:
- MISO only moves after a falling SCLK edge.
- The write-in-progress bit stays low.
- Write-enable lands after its opcode.
- A locked or aborted status write leaves the register untouched, and any change to the protection bits comes with the latch cleared.

Only the bench scenarios can show the following:
- The byte order of the three identity sequences under every selector value.
- Repeated status reads.
- The sweep of all 64 writable status patterns.
- The pin-level high-impedance state seen through a pull-up.

// File: rtl/spi_resp_pkg.sv
package spi_resp_pkg;
    localparam int BYTE_W    = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W);
    localparam int SEQ_CNT_W = 3;

    localparam logic [BYTE_W-1:0] OP_READ_ID  = 8'h9F;
    localparam logic [BYTE_W-1:0] OP_MFR_DEV  = 8'h90;
    localparam logic [BYTE_W-1:0] OP_DEV_ID   = 8'hAB;
    localparam logic [BYTE_W-1:0] OP_RD_STAT  = 8'h05;
    localparam logic [BYTE_W-1:0] OP_WR_STAT  = 8'h01;
    localparam logic [BYTE_W-1:0] OP_WR_EN    = 8'h06;
    localparam logic [BYTE_W-1:0] OP_WR_DIS   = 8'h04;

    typedef enum logic [2:0] {
        S_OPCODE,
        S_ID_READ,
        S_MFR_DEV,
        S_DEV_READ,
        S_STAT_READ,
        S_STAT_WRITE,
        S_DRAIN
    } resp_state_e;
endpackage

// File: rtl/spi_byte_rx.sv
module spi_byte_rx
    import spi_resp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 sclk_rise,
    input  logic                 mosi,
    output logic                 byte_done,
    output logic [BYTE_W-1:0]    rx_byte,
    output logic [BIT_CNT_W-1:0] bit_cnt
);
    logic [BYTE_W-1:0] shift_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q   <= '0;
            bit_cnt   <= '0;
            byte_done <= 1'b0;
            rx_byte   <= '0;
        end else if (cs_n) begin
            shift_q   <= '0;
            bit_cnt   <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (sclk_rise) begin
                shift_q <= {shift_q[BYTE_W-2:0], mosi};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == BIT_CNT_W'(BYTE_W - 1)) begin
                    byte_done <= 1'b1;
                    rx_byte   <= {shift_q[BYTE_W-2:0], mosi};
                end
            end
        end
    end
endmodule

// File: rtl/spi_byte_tx.sv
module spi_byte_tx
    import spi_resp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic              sclk_fall,
    output logic              miso_drv
);
    logic [BYTE_W-1:0] tx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q     <= '0;
            miso_drv <= 1'b0;
        end else if (cs_n) begin
            tx_q     <= '0;
            miso_drv <= 1'b0;
        end else if (load) begin
            tx_q <= load_byte;
        end else if (sclk_fall) begin
            miso_drv <= tx_q[BYTE_W-1];
            tx_q     <= {tx_q[BYTE_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg
    import spi_resp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_wel,
    input  logic              clr_wel,
    input  logic              commit_req,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              wp_n,
    output logic [BYTE_W-1:0] status
);
    localparam int PROT_W = BYTE_W - 2;

    logic [PROT_W-1:0] prot_q;
    logic              wel_q;
    logic              locked;

    assign locked = !wel_q || (prot_q[PROT_W-1] && !wp_n);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prot_q <= '0;
            wel_q  <= 1'b0;
        end else if (commit_req && !locked) begin
            prot_q <= wdata[BYTE_W-1:2];
            wel_q  <= 1'b0;
        end else if (set_wel) begin
            wel_q  <= 1'b1;
        end else if (clr_wel) begin
            wel_q  <= 1'b0;
        end
    end

    assign status = {prot_q, wel_q, 1'b0};
endmodule

// File: rtl/spi_flash_responder.sv
module spi_flash_responder
    import spi_resp_pkg::*;
#(
    parameter logic [7:0] MFR_ID   = 8'hA5,
    parameter logic [7:0] MEM_TYPE = 8'h3C,
    parameter logic [7:0] DEV_ID   = 8'h17
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic mosi,
    input  logic wp_n,
    output wire  miso
);
    logic                 sclk_q, cs_q;
    logic                 sclk_rise, sclk_fall, cs_rise;
    logic                 byte_done;
    logic [BYTE_W-1:0]    rx_byte;
    logic [BIT_CNT_W-1:0] bit_cnt;
    logic                 miso_drv;
    logic [BYTE_W-1:0]    status_w;

    resp_state_e          state, nxt_state;
    logic [SEQ_CNT_W-1:0] seq_cnt;
    logic                 dev_first_q;
    logic [BYTE_W-1:0]    pend_q;
    logic                 pend_vld_q;

    logic [BYTE_W-1:0]    reply;
    logic                 set_wel, clr_wel, commit_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            sclk_q <= sclk;
            cs_q   <= cs_n;
        end
    end

    assign sclk_rise = !cs_n && sclk && !sclk_q;
    assign sclk_fall = !cs_n && !sclk && sclk_q;
    assign cs_rise   = cs_n && !cs_q;

    spi_byte_rx u_rx (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk_rise(sclk_rise),
        .mosi(mosi), .byte_done(byte_done), .rx_byte(rx_byte), .bit_cnt(bit_cnt)
    );

    spi_byte_tx u_tx (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .load(byte_done),
        .load_byte(reply), .sclk_fall(sclk_fall), .miso_drv(miso_drv)
    );

    flash_status_reg u_stat (
        .clk(clk), .rst_n(rst_n), .set_wel(set_wel), .clr_wel(clr_wel),
        .commit_req(commit_req), .wdata(pend_q), .wp_n(wp_n), .status(status_w)
    );

    // State register and sequence bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= S_OPCODE;
            seq_cnt     <= '0;
            dev_first_q <= 1'b0;
            pend_q      <= '0;
            pend_vld_q  <= 1'b0;
        end else if (cs_n) begin
            state      <= S_OPCODE;
            seq_cnt    <= '0;
            pend_vld_q <= 1'b0;
        end else if (byte_done) begin
            state <= nxt_state;
            if (state == S_OPCODE)
                seq_cnt <= SEQ_CNT_W'(1);
            else if (seq_cnt != '1)
                seq_cnt <= seq_cnt + 1'b1;
            if (state == S_MFR_DEV && seq_cnt == SEQ_CNT_W'(3))
                dev_first_q <= rx_byte[0];
            if (state == S_STAT_WRITE && seq_cnt == SEQ_CNT_W'(1)) begin
                pend_q     <= rx_byte;
                pend_vld_q <= 1'b1;
            end
        end
    end

    // Next state and per-byte outputs
    always_comb begin
        nxt_state  = state;
        reply      = '0;
        set_wel    = 1'b0;
        clr_wel    = 1'b0;
        commit_req = cs_rise && state == S_STAT_WRITE && pend_vld_q && bit_cnt == '0;
        if (byte_done) begin
            unique case (state)
                S_OPCODE: begin
                    unique case (rx_byte)
                        OP_READ_ID: begin nxt_state = S_ID_READ; reply = MFR_ID; end
                        OP_MFR_DEV: nxt_state = S_MFR_DEV;
                        OP_DEV_ID:  nxt_state = S_DEV_READ;
                        OP_RD_STAT: begin nxt_state = S_STAT_READ; reply = status_w; end
                        OP_WR_STAT: nxt_state = S_STAT_WRITE;
                        OP_WR_EN:   begin nxt_state = S_DRAIN; set_wel = 1'b1; end
                        OP_WR_DIS:  begin nxt_state = S_DRAIN; clr_wel = 1'b1; end
                        default:    nxt_state = S_DRAIN;
                    endcase
                end
                S_ID_READ: begin
                    if (seq_cnt == SEQ_CNT_W'(1))      reply = MEM_TYPE;
                    else if (seq_cnt == SEQ_CNT_W'(2)) reply = DEV_ID;
                    else                               nxt_state = S_DRAIN;
                end
                S_MFR_DEV: begin
                    if (seq_cnt == SEQ_CNT_W'(3))      reply = rx_byte[0] ? DEV_ID : MFR_ID;
                    else if (seq_cnt == SEQ_CNT_W'(4)) reply = dev_first_q ? MFR_ID : DEV_ID;
                    else if (seq_cnt >= SEQ_CNT_W'(5)) nxt_state = S_DRAIN;
                end
                S_DEV_READ: begin
                    if (seq_cnt == SEQ_CNT_W'(3))      reply = DEV_ID;
                    else if (seq_cnt >= SEQ_CNT_W'(4)) nxt_state = S_DRAIN;
                end
                S_STAT_READ:  reply = status_w;
                S_STAT_WRITE: nxt_state = S_STAT_WRITE;
                S_DRAIN:      nxt_state = S_DRAIN;
                default:      nxt_state = S_DRAIN;
            endcase
        end
    end

    assign miso = cs_n ? 1'bz : miso_drv;
endmodule

// File: rtl/spi_flash_responder_chk.sv
module spi_flash_responder_chk
    import spi_resp_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cs_n,
    input logic                 sclk_fall,
    input logic                 cs_rise,
    input logic                 byte_done,
    input resp_state_e          state,
    input logic [BYTE_W-1:0]    rx_byte,
    input logic [BYTE_W-1:0]    status,
    input logic                 commit_req,
    input logic [BIT_CNT_W-1:0] bit_cnt,
    input logic                 miso_drv
);
    a_r10_miso_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cs_n) && !$past(sclk_fall)) |-> $stable(miso_drv));

    a_r5_wip_low: assert property (@(posedge clk) disable iff (!rst_n)
        !status[0]);

    a_r6_wren_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && state == S_OPCODE && rx_byte == OP_WR_EN) |=> status[1]);

    a_r8_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_req && !status[1]) |=> $stable(status));

    a_r9_partial_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && bit_cnt != '0) |=> $stable(status));

    a_r7_wel_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status[BYTE_W-1:2]) |-> !status[1]);
endmodule

bind spi_flash_responder spi_flash_responder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk_fall(sclk_fall),
    .cs_rise(cs_rise), .byte_done(byte_done), .state(state), .rx_byte(rx_byte),
    .status(status_w), .commit_req(commit_req), .bit_cnt(bit_cnt), .miso_drv(miso_drv)
);

// File: tb/spi_flash_responder_bench.sv
module spi_flash_responder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam logic [7:0] P_MFR = 8'hA5;
    localparam logic [7:0] P_MEM = 8'h3C;
    localparam logic [7:0] P_DEV = 8'h17;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic mosi = 1'b0;
    logic wp_n = 1'b1;
    wire  miso_w;
    pullup (miso_w);

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_flash_responder #(.MFR_ID(P_MFR), .MEM_TYPE(P_MEM), .DEV_ID(P_DEV)) u_spi_flash_responder (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
        .mosi(mosi), .wp_n(wp_n), .miso(miso_w)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    task automatic sel_on;
        @(negedge clk); cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic sel_off;
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] dout, input int nbits, output logic [7:0] din);
        din = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            @(negedge clk); mosi = dout[i];
            repeat (HALF) @(negedge clk);
            din[i] = miso_w;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic one_cmd(input logic [7:0] op);
        logic [7:0] d;
        sel_on; xfer(op, 8, d); sel_off;
    endtask

    task automatic rd_stat(output logic [7:0] s);
        logic [7:0] d;
        sel_on; xfer(8'h05, 8, d); xfer(8'h00, 8, s); sel_off;
    endtask

    task automatic wr_stat(input logic [7:0] v);
        logic [7:0] d;
        sel_on; xfer(8'h01, 8, d); xfer(v, 8, d); sel_off;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=0x01 expected=0x00");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] d, s, exp_a, exp_b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R10: deselected line floats (pull-up reads 1)
        chk("R10 hi-z at reset", {7'd0, miso_w}, 8'h01);
        // R5: reset status
        rd_stat(s); chk("R5 reset status", s, 8'h00);

        // R1: identity order, then drain zeros
        sel_on; xfer(8'h9F, 8, d);
        xfer(8'h00, 8, d); chk("R1 mfr", d, P_MFR);
        xfer(8'h00, 8, d); chk("R1 memtype", d, P_MEM);
        xfer(8'h00, 8, d); chk("R1 dev", d, P_DEV);
        xfer(8'h00, 8, d); chk("R1 drain", d, 8'h00);
        sel_off;

        // R2: selector sweep
        for (int sel = 0; sel < 4; sel++) begin
            exp_a = sel[0] ? P_DEV : P_MFR;
            exp_b = sel[0] ? P_MFR : P_DEV;
            sel_on; xfer(8'h90, 8, d); xfer(8'hFF, 8, d); xfer(8'h00, 8, d);
            xfer(8'(sel), 8, d);
            xfer(8'h00, 8, d); chk("R2 first id", d, exp_a);
            xfer(8'h00, 8, d); chk("R2 second id", d, exp_b);
            sel_off;
        end

        // R3: three dummies then device id
        sel_on; xfer(8'hAB, 8, d);
        for (int k = 0; k < 3; k++) xfer(8'h55, 8, d);
        xfer(8'h00, 8, d); chk("R3 dev", d, P_DEV);
        sel_off;

        // R6: latch set / clear; R4 repeated reads
        one_cmd(8'h06);
        sel_on; xfer(8'h05, 8, d);
        for (int k = 0; k < 4; k++) begin
            xfer(8'h00, 8, d); chk("R4 repeated status", d, 8'h02);
        end
        sel_off;
        chk("R6 wel set", d, 8'h02);
        one_cmd(8'h04);
        rd_stat(s); chk("R6 wel clear", s, 8'h00);

        // R8: write with latch clear is discarded
        wr_stat(8'hFC);
        rd_stat(s); chk("R8 no wel", s, 8'h00);

        // R7: sweep all writable patterns
        for (int v = 0; v < 64; v++) begin
            one_cmd(8'h06);
            wr_stat(8'((v << 2) | 3));
            rd_stat(s); chk("R7 sweep", s, 8'(v << 2));
        end
        one_cmd(8'h06);
        sel_on; xfer(8'h01, 8, d); xfer(8'h28, 8, d); xfer(8'hFF, 8, d); sel_off;
        rd_stat(s); chk("R7 two-byte write", s, 8'h28);

        // R8: protection with write-protect low
        one_cmd(8'h06); wr_stat(8'h84);
        rd_stat(s); chk("R8 set srwd", s, 8'h84);
        wp_n = 1'b0;
        one_cmd(8'h06); wr_stat(8'h00);
        rd_stat(s); chk("R8 locked", s, 8'h86);
        wp_n = 1'b1;
        wr_stat(8'h10);
        rd_stat(s); chk("R8 unlocked", s, 8'h10);

        // R9: aborted writes
        one_cmd(8'h06);
        sel_on; xfer(8'h01, 8, d); xfer(8'h40, 8, d); xfer(8'hFF, 4, d); sel_off;
        rd_stat(s); chk("R9 mid-byte abort", s, 8'h12);
        sel_on; xfer(8'h01, 8, d); sel_off;
        rd_stat(s); chk("R9 opcode only", s, 8'h12);
        sel_on; xfer(8'h01, 8, d); xfer(8'h80, 5, d); sel_off;
        rd_stat(s); chk("R9 partial data byte", s, 8'h12);

        // R11 / R10: unknown opcode drives zeros, then floats
        sel_on; xfer(8'h5A, 8, d);
        xfer(8'hFF, 8, d); chk("R11 unknown reads zero", d, 8'h00);
        xfer(8'hFF, 8, d); chk("R10 driven low while selected", d, 8'h00);
        sel_off;
        chk("R10 hi-z after deselect", {7'd0, miso_w}, 8'h01);
        rd_stat(s); chk("R11 status kept", s, 8'h12);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule